// File: doc/BRIEF.md
# PCIe Root-Port Interrupt Register Block

This block gathers the interrupt causes of a PCIe root-port bridge into one 32-bit status word and folds them into a single level interrupt line. Six root-complex events arrive as one-cycle pulses and are latched in sticky bits: completion timeout, two power-management messages, and three error severities. The four legacy INTx wires arrive as levels and are shown live in an 8-bit field, one line on every other bit.

Software reaches the block through a plain 32-bit register port with write strobe, read strobe, byte address and write data. Read data comes back one cycle after the read strobe, marked by a valid pulse; the port never stalls, so there is no back-pressure. The mask cannot be written directly. One register clears mask bits and another sets them, so interrupt handlers that touch different sources need no read-modify-write. Pending events are acknowledged by writing ones to the status word. The interrupt output is high while any status bit is set and its mask bit is clear.

Top module: `pcie_rp_irq_regs`

## Requirements
- R1: After reset the status word reads 0x0000_0000, the mask reads 0x1F55_8000 (every implemented bit masked) and `irq_o` is low.
- R2: The registers sit at byte offsets from `BASE`: status +0x0, mask +0x4, unmask +0x8 and mask-set +0xC. Read data appears with `reg_rvalid` one cycle after `reg_rd`. The unmask and mask-set registers read as zero, and so does any other address.
- R3: A write to the unmask register clears each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: A write to the mask-set register sets each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R5: A pulse on `ev_i[k]` sets a sticky status bit, whether or not that bit is masked. The bit positions are: k=0 completion timeout at bit 15, k=1 power-management event message at bit 24, k=2 turn-off acknowledge at bit 25, k=3 correctable error at bit 26, k=4 non-fatal error at bit 27, k=5 fatal error at bit 28.
- R6: Writing 1 to an event bit in the status register clears it, and writing 0 leaves it set. If an event pulse lands in the same cycle as a clear of its bit, the bit stays set.
- R7: INTx line n appears at status bit 16+2n (bits 16, 18, 20, 22). The bit follows the input level with one cycle of delay, and writes to the status register do not clear it.
- R8: `irq_o` is high exactly when some status bit is set whose mask bit is 0. It changes in the same cycle as the status or mask register that causes the change.
- R9: Bits outside 0x1F55_8000 read as 0 in the status and mask registers, and writes to them in any register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | 6 | One-cycle event pulses, index order as in R5 |
| intx_i | input | 4 | Legacy INTx levels, line n on bit n |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq_o | output | 1 | Level interrupt output |

## Verification
Each result has a fixed due cycle. Every register write and event pulse takes effect at the next clock edge. An INTx level is registered once. Read data and its valid flag follow the read strobe by exactly one edge. `irq_o` is combinational from the registers, so it settles in the same cycle as the register update. The bench drives on falling edges and samples on falling edges. A read therefore returns the register state as it stands after every stimulus driven before it. The scoreboard pops one expected word for each valid pulse and counts a missing or extra response as a failure.

// File: rtl/pcie_irq_pkg.sv
`timescale 1ns/1ps
package pcie_irq_pkg;
  localparam int EV_N   = 6;
  localparam int INTX_N = 4;
  localparam int DW     = 32;

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_MASK    = 2'd1,
    SEL_UNMASK  = 2'd2,
    SEL_MASKSET = 2'd3
  } reg_sel_e;

  // Status bit position of event k
  function automatic int ev_pos(input int k);
    return (k == 0) ? 15 : 23 + k;
  endfunction

  // Status bit position of INTx line n
  function automatic int intx_pos(input int n);
    return 16 + 2 * n;
  endfunction

  function automatic logic [DW-1:0] ev_bits();
    logic [DW-1:0] m;
    m = '0;
    for (int k = 0; k < EV_N; k++) m[ev_pos(k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] intx_bits();
    logic [DW-1:0] m;
    m = '0;
    for (int n = 0; n < INTX_N; n++) m[intx_pos(n)] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] EV_BITS   = ev_bits();
  localparam logic [DW-1:0] INTX_BITS = intx_bits();
  localparam logic [DW-1:0] IMPL_BITS = EV_BITS | INTX_BITS;
endpackage

// File: rtl/pcie_irq_decode.sv
`timescale 1ns/1ps
module pcie_irq_decode
  import pcie_irq_pkg::*;
#(
  parameter int              AW   = 12,
  parameter logic [AW-1:0]   BASE = 12'h4C0
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output reg_sel_e      sel_o
);
  localparam int BLK_LSB = 4;

  always_comb begin
    hit_o = (addr_i[AW-1:BLK_LSB] == BASE[AW-1:BLK_LSB]) && (addr_i[1:0] == 2'b00);
    sel_o = reg_sel_e'(addr_i[3:2]);
  end
endmodule

// File: rtl/pcie_irq_status.sv
`timescale 1ns/1ps
module pcie_irq_status
  import pcie_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EV_N-1:0]   ev_i,
  input  logic [INTX_N-1:0] intx_i,
  input  logic [DW-1:0]     clr_i,
  output logic [DW-1:0]     status_o
);
  logic [EV_N-1:0]   ev_q;
  logic [INTX_N-1:0] intx_q;

  for (genvar k = 0; k < EV_N; k++) begin : g_ev
    always_ff @(posedge clk) begin
      if (!rst_n)                ev_q[k] <= 1'b0;
      else if (ev_i[k])          ev_q[k] <= 1'b1;   // new event beats clear
      else if (clr_i[ev_pos(k)]) ev_q[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) intx_q <= '0;
    else        intx_q <= intx_i;
  end

  always_comb begin
    status_o = '0;
    for (int k = 0; k < EV_N; k++)   status_o[ev_pos(k)]   = ev_q[k];
    for (int n = 0; n < INTX_N; n++) status_o[intx_pos(n)] = intx_q[n];
  end
endmodule

// File: rtl/pcie_irq_mask.sv
`timescale 1ns/1ps
module pcie_irq_mask
  import pcie_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] unmask_i,
  input  logic [DW-1:0] maskset_i,
  output logic [DW-1:0] mask_o
);
  logic [DW-1:0] mask_q;

  // maskset is applied after unmask, so setting wins on a shared bit
  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= IMPL_BITS;
    else        mask_q <= ((mask_q & ~unmask_i) | maskset_i) & IMPL_BITS;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/pcie_rp_irq_regs.sv
`timescale 1ns/1ps
module pcie_rp_irq_regs
  import pcie_irq_pkg::*;
#(
  parameter int            AW   = 12,
  parameter logic [AW-1:0] BASE = 12'h4C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EV_N-1:0]   ev_i,
  input  logic [INTX_N-1:0] intx_i,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_rvalid,
  output logic              irq_o
);
  logic          hit;
  reg_sel_e      sel;
  logic [DW-1:0] status_q, mask_q;
  logic [DW-1:0] clr_v, unmask_v, maskset_v, rd_mux;
  logic [DW-1:0] wd_impl;

  pcie_irq_decode #(.AW(AW), .BASE(BASE)) u_dec (
    .addr_i (reg_addr),
    .hit_o  (hit),
    .sel_o  (sel)
  );

  always_comb begin
    wd_impl   = reg_wdata & IMPL_BITS;
    clr_v     = (reg_wr && hit && sel == SEL_STATUS)  ? (wd_impl & EV_BITS) : '0;
    unmask_v  = (reg_wr && hit && sel == SEL_UNMASK)  ? wd_impl : '0;
    maskset_v = (reg_wr && hit && sel == SEL_MASKSET) ? wd_impl : '0;
  end

  pcie_irq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (ev_i),
    .intx_i   (intx_i),
    .clr_i    (clr_v),
    .status_o (status_q)
  );

  pcie_irq_mask u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .unmask_i  (unmask_v),
    .maskset_i (maskset_v),
    .mask_o    (mask_q)
  );

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (sel)
        SEL_STATUS: rd_mux = status_q;
        SEL_MASK:   rd_mux = mask_q;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  assign irq_o = |(status_q & ~mask_q);
endmodule

// File: rtl/pcie_irq_chk.sv
`timescale 1ns/1ps
module pcie_irq_chk
  import pcie_irq_pkg::*;
#(
  parameter int            AW   = 12,
  parameter logic [AW-1:0] BASE = 12'h4C0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [EV_N-1:0]   ev_i,
  input logic [INTX_N-1:0] intx_i,
  input logic              reg_wr,
  input logic [AW-1:0]     reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     status_q,
  input logic [DW-1:0]     mask_q,
  input logic              irq_o
);
  logic wr_stat, wr_unm, wr_mset;
  assign wr_stat = reg_wr && (reg_addr == BASE);
  assign wr_unm  = reg_wr && (reg_addr == BASE + AW'(8));
  assign wr_mset = reg_wr && (reg_addr == BASE + AW'(12));

  AST_EV_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i[0] |=> status_q[15]);                                        // R5
  AST_EV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[28] && !(wr_stat && reg_wdata[28])) |=> status_q[28]);  // R6
  AST_EV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i[5] && wr_stat && reg_wdata[28]) |=> status_q[28]);          // R6
  AST_INTX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_q[22] == $past(intx_i[3])));                     // R7
  AST_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_unm && reg_wdata[24]) |=> !mask_q[24]);                       // R3
  AST_MASKSET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mset && reg_wdata[24]) |=> mask_q[24]);                       // R4
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q | mask_q) & ~IMPL_BITS) == '0);                        // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == IMPL_BITS) |-> !irq_o);                                // R8
endmodule

bind pcie_rp_irq_regs pcie_irq_chk #(.AW(AW), .BASE(BASE)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_i      (ev_i),
  .intx_i    (intx_i),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .irq_o     (irq_o)
);

// File: tb/pcie_rp_irq_regs_tb_top.sv
`timescale 1ns/1ps
module pcie_rp_irq_regs_tb_top;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_STAT = 12'h4C0;
  localparam logic [AW-1:0] A_MASK = 12'h4C4;
  localparam logic [AW-1:0] A_UNM  = 12'h4C8;
  localparam logic [AW-1:0] A_MSET = 12'h4CC;
  localparam logic [31:0]   ALL    = 32'h1F55_8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] ev_i = '0;
  logic [3:0] intx_i = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid, irq_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  pcie_rp_irq_regs #(.AW(AW), .BASE(12'h4C0)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .intx_i(intx_i),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected word per read response
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) check("R2 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] v);
    @(negedge clk); ev_i = v;
    @(negedge clk); ev_i = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    rd(A_STAT, 32'h0, "R1 status reset");
    rd(A_MASK, ALL, "R1 mask reset");
    rd(A_UNM, 32'h0, "R2 unmask reads zero");
    rd(A_MSET, 32'h0, "R2 maskset reads zero");
    rd(12'h4D0, 32'h0, "R2 other address");

    pulse(6'b111111);
    rd(A_STAT, 32'h1F00_8000, "R5 event positions while masked");
    check("R8 masked no irq", {31'd0, irq_o}, 32'd0);

    wr(A_UNM, 32'h0000_8000);
    rd(A_MASK, 32'h1F55_0000, "R3 unmask one bit");
    check("R8 irq on unmasked pending", {31'd0, irq_o}, 32'd1);

    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h1F00_8000, "R6 write zero keeps");
    wr(A_STAT, 32'h0000_8000);
    rd(A_STAT, 32'h1F00_0000, "R6 w1c clears");
    check("R8 irq drops after clear", {31'd0, irq_o}, 32'd0);

    wr(A_UNM, 32'hFFFF_FFFF);
    rd(A_MASK, 32'h0, "R3 unmask all, R9 no extra bits");
    check("R8 irq all unmasked", {31'd0, irq_o}, 32'd1);
    wr(A_MSET, 32'h1000_0000);
    rd(A_MASK, 32'h1000_0000, "R4 maskset one bit");
    wr(A_STAT, 32'h0F00_0000);
    rd(A_STAT, 32'h1000_0000, "R6 partial clear");
    check("R8 only masked pending", {31'd0, irq_o}, 32'd0);

    // event and clear in one cycle
    @(negedge clk); ev_i = 6'b100000; reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h1000_0000;
    @(negedge clk); ev_i = '0; reg_wr = 1'b0;
    rd(A_STAT, 32'h1000_0000, "R6 event beats clear");

    @(negedge clk); intx_i = 4'b0101;
    @(negedge clk);
    check("R7 intx raises irq", {31'd0, irq_o}, 32'd1);
    rd(A_STAT, 32'h1011_0000, "R7 intx positions");
    wr(A_STAT, 32'h00FF_0000);
    rd(A_STAT, 32'h1011_0000, "R7 intx not cleared by write");
    intx_i = 4'b0000;
    @(negedge clk);
    check("R7 intx drop clears irq", {31'd0, irq_o}, 32'd0);
    rd(A_STAT, 32'h1000_0000, "R7 intx follows level");
    @(negedge clk); intx_i = 4'b1000;
    @(negedge clk);
    rd(A_STAT, 32'h1040_0000, "R7 line 3 at bit 22");
    intx_i = 4'b0000;

    wr(A_STAT, 32'hE0AA_7FFF);
    rd(A_STAT, 32'h1000_0000, "R9 unimplemented status write");
    wr(A_MSET, 32'hE0AA_7FFF);
    rd(A_MASK, 32'h1000_0000, "R9 unimplemented maskset write");
    wr(A_MSET, 32'hFFFF_FFFF);
    rd(A_MASK, ALL, "R4 maskset all");
    wr(A_STAT, 32'h1000_0000);
    rd(A_STAT, 32'h0, "R6 final clear");
    check("R8 idle irq", {31'd0, irq_o}, 32'd0);

    repeat (3) @(negedge clk);
    check("R2 responses outstanding", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule